// File: doc/BRIEF.md
# Stereo Codec Serial Audio Port

This block is the digital serial port of a stereo 24-bit audio codec working as a bus slave. An external controller supplies the bit clock (64 bit clocks per sample period) and the frame clock. The frame clock is high for the left channel slot and low for the right channel slot, and each slot is 32 bit clocks long. The port carries two streams at once. Outbound converter words leave on the serial output left-aligned in their slot, most significant bit first. Inbound playback words arrive right-aligned in their slot, most significant bit first. Both streams are two's complement.

All logic runs on a fast core clock. The serial clocks are brought in through synchronizers and oversampled, and edges are detected on the core clock. The core presents a left/right word pair, which the port captures at the start of every frame. Each received pair is handed to the core with a single-cycle strobe.

The port also controls when outbound data may be sent. While the power-down input is low, everything is held cleared. After power-down is released, the outbound stream stays at zero for a programmable number of frames while the converter settles (2081 by default). A separate force-zero input silences the outbound stream while a reduced-rate playback mode is active.

Top module: `codec_serial_port`

## Requirements
- R1: After reset with power-down asserted, `sdto_o` is 0, `rx_valid_o` is 0 and both received words are zero.
- R2: In each slot, the 24 outbound bits appear MSB first in slot bits 0 to 23. Slot bit 0 is driven right after the frame clock edge, and each later bit follows a bit-clock falling edge. Slot bits 24 to 31 are driven 0.
- R3: A frame begins at a frame-clock rising edge. The slot while the frame clock is high carries the left word, and the slot while it is low carries the right word.
- R4: `sdti_i` is sampled on bit-clock rising edges. Slot bits 8 to 31 form the received word, MSB first, so slot bit 31 is the LSB. Slot bits 0 to 7 have no effect on the received word.
- R5: One core cycle after the last bit of a right slot is sampled, `rx_valid_o` pulses for exactly one cycle. At that point `rx_left_o` and `rx_right_o` hold the left and right words of that frame, and they change at no other time.
- R6: The outbound pair is captured at the frame-clock rising edge. A change on `tx_left_i` or `tx_right_i` during a frame first shows in the next frame.
- R7: After `pdn_i` rises, frames starting on the first INIT_FRAMES frame-clock rising edges carry all zeros. From rising edge INIT_FRAMES+1 on, frames carry the core data.
- R8: If `adc_force_zero_i` is high at a frame start, that frame carries all zeros. Settling frames are still counted while it is high.
- R9: While `pdn_i` is low, the port is cleared synchronously: zero output, zero received words, no strobe. The settling count restarts.
- R10: The extreme codes 0x800000 and 0x7FFFFF pass bit-exact in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, faster than 4x the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pdn_i | input | 1 | Low holds the port powered down and cleared |
| adc_force_zero_i | input | 1 | Reduced-rate playback mode; outbound frames go to zero |
| bclk_i | input | 1 | Serial bit clock from the controller |
| lrck_i | input | 1 | Frame clock, high = left slot |
| sdti_i | input | 1 | Serial playback data in |
| tx_left_i | input | WORD_BITS | Outbound left word from the core |
| tx_right_i | input | WORD_BITS | Outbound right word from the core |
| sdto_o | output | 1 | Serial converter data out |
| rx_left_o | output | WORD_BITS | Last received left word |
| rx_right_o | output | WORD_BITS | Last received right word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
The settling gate and the force-zero gate both act at the same frame-start capture, so both can decide the same frame. The bench provokes this after a power-down cycle. It holds force-zero high through every settling frame and through the frame on which settling completes, then releases it. The next frame must carry real data at once, which shows that the settling count kept advancing underneath the force. The bench also changes the core words in the middle of a frame that is being received and sent, and expects the old words on the wire together with an unaffected received pair.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  typedef enum logic {CH_RIGHT = 1'b0, CH_LEFT = 1'b1} chan_e;
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int N      = 3,
  parameter int EDGE_W = 2,
  parameter int STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        din_i,
  output logic [N-EDGE_W-1:0] lvl_o,
  output logic [EDGE_W-1:0]   rise_o,
  output logic [EDGE_W-1:0]   fall_o
);
  logic [N-1:0]      stg_q [STAGES];
  logic [EDGE_W-1:0] prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prv_q <= '0;
    end else begin
      stg_q[0] <= din_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prv_q <= stg_q[STAGES-1][EDGE_W-1:0];
    end
  end

  // low bits get edge detection, the rest are passed as levels
  assign rise_o = stg_q[STAGES-1][EDGE_W-1:0] & ~prv_q;
  assign fall_o = ~stg_q[STAGES-1][EDGE_W-1:0] & prv_q;
  assign lvl_o  = stg_q[STAGES-1][N-1:EDGE_W];
endmodule

// File: rtl/cp_init_gate.sv
module cp_init_gate #(
  parameter int INIT_FRAMES = 2081
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_i,
  input  logic frame_start_i,
  output logic ready_o
);
  localparam int CW = (INIT_FRAMES < 1) ? 1 : $clog2(INIT_FRAMES + 1);
  localparam logic [CW-1:0] DONE = CW'(INIT_FRAMES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!pdn_i)                       cnt_q <= '0;
    else if (frame_start_i && cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == DONE);
endmodule

// File: rtl/cp_tx_path.sv
module cp_tx_path import codec_port_pkg::*; #(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32,
  localparam int CNT_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pdn_i,
  input  logic                 frame_start_i,
  input  logic                 gate_zero_i,
  input  logic [CNT_W-1:0]     slot_cnt_i,
  input  chan_e                chan_i,
  input  logic [WORD_BITS-1:0] left_i,
  input  logic [WORD_BITS-1:0] right_i,
  output logic                 sdto_o
);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BITS - 1);

  logic [WORD_BITS-1:0] shd_l_q, shd_r_q, word, shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_l_q <= '0;
      shd_r_q <= '0;
    end else if (!pdn_i) begin
      shd_l_q <= '0;
      shd_r_q <= '0;
    end else if (frame_start_i) begin
      shd_l_q <= gate_zero_i ? '0 : left_i;
      shd_r_q <= gate_zero_i ? '0 : right_i;
    end
  end

  always_comb begin
    word    = (chan_i == CH_LEFT) ? shd_l_q : shd_r_q;
    shifted = word << slot_cnt_i;
    sdto_o  = (slot_cnt_i <= WORD_LAST) && shifted[WORD_BITS-1];
  end
endmodule

// File: rtl/cp_rx_path.sv
module cp_rx_path import codec_port_pkg::*; #(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32,
  localparam int CNT_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pdn_i,
  input  logic                 bit_stb_i,
  input  logic                 sdti_i,
  input  logic [CNT_W-1:0]     slot_cnt_i,
  input  chan_e                chan_i,
  output logic [WORD_BITS-1:0] left_o,
  output logic [WORD_BITS-1:0] right_o,
  output logic                 valid_o
);
  localparam logic [CNT_W-1:0] PAD_C  = CNT_W'(SLOT_BITS - WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SLOT_BITS - 1);

  logic [WORD_BITS-1:0] sh_q, hold_l_q, nxt;

  assign nxt = {sh_q[WORD_BITS-2:0], sdti_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; hold_l_q <= '0; left_o <= '0; right_o <= '0; valid_o <= 1'b0;
    end else if (!pdn_i) begin
      sh_q <= '0; hold_l_q <= '0; left_o <= '0; right_o <= '0; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      // leading pad bits of the slot are skipped
      if (bit_stb_i && slot_cnt_i >= PAD_C) begin
        sh_q <= nxt;
        if (slot_cnt_i == LAST_C) begin
          if (chan_i == CH_LEFT) hold_l_q <= nxt;
          else begin
            left_o  <= hold_l_q;
            right_o <= nxt;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port import codec_port_pkg::*; #(
  parameter int WORD_BITS   = 24,
  parameter int SLOT_BITS   = 32,
  parameter int INIT_FRAMES = 2081,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pdn_i,
  input  logic                 adc_force_zero_i,
  input  logic                 bclk_i,
  input  logic                 lrck_i,
  input  logic                 sdti_i,
  input  logic [WORD_BITS-1:0] tx_left_i,
  input  logic [WORD_BITS-1:0] tx_right_i,
  output logic                 sdto_o,
  output logic [WORD_BITS-1:0] rx_left_o,
  output logic [WORD_BITS-1:0] rx_right_o,
  output logic                 rx_valid_o
);
  localparam int CNT_W = $clog2(SLOT_BITS);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SLOT_BITS - 1);

  logic [0:0]       sdti_s;
  logic [1:0]       rise, fall;
  logic             bclk_rise, bclk_fall, lrck_rise, lrck_fall, lrck_edge;
  logic [CNT_W-1:0] slot_cnt;
  chan_e            chan_q;
  logic             init_ready;

  cp_sync #(.N(3), .EDGE_W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  ({sdti_i, lrck_i, bclk_i}),
    .lvl_o  (sdti_s),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign bclk_rise = rise[0];
  assign bclk_fall = fall[0];
  assign lrck_rise = rise[1];
  assign lrck_fall = fall[1];
  assign lrck_edge = lrck_rise | lrck_fall;

  // frame clock edge wins over a coincident bit clock fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt <= '0;
      chan_q   <= CH_RIGHT;
    end else if (!pdn_i) begin
      slot_cnt <= '0;
      chan_q   <= CH_RIGHT;
    end else if (lrck_edge) begin
      slot_cnt <= '0;
      chan_q   <= lrck_rise ? CH_LEFT : CH_RIGHT;
    end else if (bclk_fall && slot_cnt != LAST_C) begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  cp_init_gate #(.INIT_FRAMES(INIT_FRAMES)) u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pdn_i         (pdn_i),
    .frame_start_i (lrck_rise),
    .ready_o       (init_ready)
  );

  cp_tx_path #(.WORD_BITS(WORD_BITS), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pdn_i         (pdn_i),
    .frame_start_i (lrck_rise),
    .gate_zero_i   (!init_ready || adc_force_zero_i),
    .slot_cnt_i    (slot_cnt),
    .chan_i        (chan_q),
    .left_i        (tx_left_i),
    .right_i       (tx_right_i),
    .sdto_o        (sdto_o)
  );

  cp_rx_path #(.WORD_BITS(WORD_BITS), .SLOT_BITS(SLOT_BITS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pdn_i      (pdn_i),
    .bit_stb_i  (bclk_rise),
    .sdti_i     (sdti_s[0]),
    .slot_cnt_i (slot_cnt),
    .chan_i     (chan_q),
    .left_o     (rx_left_o),
    .right_o    (rx_right_o),
    .valid_o    (rx_valid_o)
  );
endmodule

// File: rtl/codec_serial_port_chk.sv
module codec_serial_port_chk #(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32,
  localparam int CNT_W    = $clog2(SLOT_BITS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pdn_i,
  input logic                 sdto_o,
  input logic [WORD_BITS-1:0] rx_left_o,
  input logic [WORD_BITS-1:0] rx_right_o,
  input logic                 rx_valid_o,
  input logic [CNT_W-1:0]     slot_cnt,
  input logic                 init_ready
);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BITS - 1);

  p_filler_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_cnt > WORD_LAST) |-> !sdto_o);

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_rx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_o && pdn_i && $past(pdn_i)) |->
      ($stable(rx_left_o) && $stable(rx_right_o)));

  p_init_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_ready |-> !sdto_o);

  p_pdn_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_i |=> (!sdto_o && !rx_valid_o && rx_left_o == '0 && rx_right_o == '0));
endmodule

bind codec_serial_port codec_serial_port_chk #(
  .WORD_BITS (WORD_BITS),
  .SLOT_BITS (SLOT_BITS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pdn_i      (pdn_i),
  .sdto_o     (sdto_o),
  .rx_left_o  (rx_left_o),
  .rx_right_o (rx_right_o),
  .rx_valid_o (rx_valid_o),
  .slot_cnt   (slot_cnt),
  .init_ready (init_ready)
);

// File: tb/sim_codec_serial_port.sv
`timescale 1ns/1ps
module sim_codec_serial_port;
  localparam int INIT = 3;

  logic clk = 1'b0;
  logic rst_ni, pdn, force_zero, bclk, lrck, sdti;
  logic [23:0] tx_l, tx_r;
  logic sdto_o, rx_valid_o;
  logic [23:0] rx_left_o, rx_right_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [47:0] rx_q[$];
  string       rx_tag_q[$];
  logic        vld_prev = 1'b0;

  always #2.5 clk = ~clk;

  codec_serial_port #(.INIT_FRAMES(INIT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pdn_i(pdn), .adc_force_zero_i(force_zero),
    .bclk_i(bclk), .lrck_i(lrck), .sdti_i(sdti),
    .tx_left_i(tx_l), .tx_right_i(tx_r),
    .sdto_o(sdto_o), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
    .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for received pairs
  always @(negedge clk) begin
    if (rx_valid_o) begin
      if (vld_prev) chk(1'b0, "R5", "strobe longer than one cycle", 48'd2, 48'd1);
      else if (rx_q.size() == 0) chk(1'b0, "R5", "unexpected pair", {rx_left_o, rx_right_o}, 48'd0);
      else begin
        logic [47:0] e;
        string t;
        e = rx_q.pop_front();
        t = rx_tag_q.pop_front();
        chk({rx_left_o, rx_right_o} == e, t, "received pair", {rx_left_o, rx_right_o}, e);
      end
    end
    vld_prev <= rx_valid_o;
  end

  // one 64-bit frame; bit clock half period = 5 core cycles
  task automatic run_frame(input logic [23:0] rl, input logic [23:0] rr,
                           input logic [23:0] el, input logic [23:0] er,
                           input bit mid, input string ttag, input string rtag);
    rx_q.push_back({rl, rr});
    rx_tag_q.push_back(rtag);
    for (int ch = 0; ch < 2; ch++) begin
      logic [23:0] got, src, exp;
      logic [7:0]  fill, junk;
      src  = (ch == 0) ? rl : rr;
      exp  = (ch == 0) ? el : er;
      junk = (ch == 0) ? 8'hA5 : 8'h5A;
      got  = '0;
      fill = '0;
      for (int b = 0; b < 32; b++) begin
        @(negedge clk);
        bclk = 1'b0;
        if (b == 0) lrck = (ch == 0);
        sdti = (b < 8) ? junk[b] : src[31-b];
        repeat (5) @(negedge clk);
        if (b < 24) got[23-b] = sdto_o;
        else        fill[b-24] = sdto_o;
        if (mid && ch == 0 && b == 10) begin
          tx_l = ~tx_l;
          tx_r = ~tx_r;
        end
        bclk = 1'b1;
        repeat (4) @(negedge clk);
      end
      chk(got == exp, ttag, (ch == 0) ? "left word on wire" : "right word on wire",
          {24'd0, got}, {24'd0, exp});
      chk(fill == 8'd0, "R2", "slot filler bits", {40'd0, fill}, 48'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pdn = 1'b0; force_zero = 1'b0;
    bclk = 1'b1; lrck = 1'b0; sdti = 1'b0;
    tx_l = 24'h123456; tx_r = 24'hABCDEF;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdto_o == 1'b0, "R1", "sdto after reset", {47'd0, sdto_o}, 48'd0);
    chk(rx_valid_o == 1'b0, "R1", "strobe after reset", {47'd0, rx_valid_o}, 48'd0);
    chk({rx_left_o, rx_right_o} == 48'd0, "R1", "rx words after reset",
        {rx_left_o, rx_right_o}, 48'd0);

    pdn = 1'b1;
    // R7: settling frames carry zeros, rx works meanwhile (R4)
    for (int f = 0; f < INIT; f++)
      run_frame(24'h0F00F0 + 24'(f), 24'hC3C3C3 - 24'(f), 24'd0, 24'd0, 1'b0, "R7", "R4");
    run_frame(24'h800000, 24'h7FFFFF, 24'h123456, 24'hABCDEF, 1'b0, "R7", "R10");
    tx_l = 24'h800000; tx_r = 24'h7FFFFF;
    run_frame(24'h3A5C71, 24'hE4D2B9, 24'h800000, 24'h7FFFFF, 1'b0, "R10", "R4");
    tx_l = 24'hAAAAAA; tx_r = 24'h555555;
    run_frame(24'h000001, 24'hFFFFFE, 24'hAAAAAA, 24'h555555, 1'b0, "R3", "R4");
    // R6: mid-frame core update
    tx_l = 24'h13579B; tx_r = 24'h2468AC;
    run_frame(24'h112233, 24'h445566, 24'h13579B, 24'h2468AC, 1'b1, "R6", "R5");
    run_frame(24'h778899, 24'hAABBCC, ~24'h13579B, ~24'h2468AC, 1'b0, "R6", "R5");
    // R8: force-zero
    tx_l = 24'h0A0B0C; tx_r = 24'hD0E0F0;
    force_zero = 1'b1;
    run_frame(24'h654321, 24'h0FEDCB, 24'd0, 24'd0, 1'b0, "R8", "R4");
    force_zero = 1'b0;
    run_frame(24'h13243B, 24'hCAFE01, 24'h0A0B0C, 24'hD0E0F0, 1'b0, "R8", "R4");

    // R9: power-down clears
    pdn = 1'b0;
    repeat (20) @(negedge clk);
    chk(sdto_o == 1'b0, "R9", "sdto in power-down", {47'd0, sdto_o}, 48'd0);
    chk({rx_left_o, rx_right_o} == 48'd0, "R9", "rx words in power-down",
        {rx_left_o, rx_right_o}, 48'd0);
    chk(rx_valid_o == 1'b0, "R9", "strobe in power-down", {47'd0, rx_valid_o}, 48'd0);

    // R8 with R7: force held across settling completion
    pdn = 1'b1;
    force_zero = 1'b1;
    for (int f = 0; f <= INIT; f++)
      run_frame(24'h5A5A00 + 24'(f), 24'h00A5A5 + 24'(f), 24'd0, 24'd0, 1'b0, "R8", "R4");
    force_zero = 1'b0;
    run_frame(24'h9ABCDE, 24'h123987, 24'h0A0B0C, 24'hD0E0F0, 1'b0, "R8", "R4");

    // R9: settling count restarts after another power-down
    pdn = 1'b0;
    repeat (10) @(negedge clk);
    pdn = 1'b1;
    for (int f = 0; f < INIT; f++)
      run_frame(24'h314159 + 24'(f), 24'h271828 + 24'(f), 24'd0, 24'd0, 1'b0, "R9", "R4");
    run_frame(24'h161803, 24'h141421, 24'h0A0B0C, 24'hD0E0F0, 1'b0, "R9", "R4");

    repeat (20) @(negedge clk);
    chk(rx_q.size() == 0, "R5", "pairs never strobed", 48'(rx_q.size()), 48'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule